// File: doc/BRIEF.md
# SPI Serial Memory Command Engine

This block is the slave side of a serial memory device. It watches the chip select, serial clock and serial data input pins and decodes an 8-bit command. Depending on the command, it then collects a 24-bit address and, for the fast read, eight dummy clocks. It turns the serial traffic into single-byte read and write requests on a synchronous RAM port that holds 262,144 bytes. Read data, the status byte and a fixed 32-bit identifier are shifted back out on a data output with a separate output-enable.

All logic runs on one system clock, which must be at least ten times faster than the serial clock. The three pin inputs pass through a two-flop synchroniser, and clock edges are detected from the synchronised samples. Writes to the array and to the status byte need the internal write-enable latch to be set. They also need the external `wr_permit` input to be high, which carries the result of any protection check made outside the block. The RAM answers a read request on the cycle after the request.

Top module: `spi_mem_engine`

## Requirements
- R1: Coming out of reset, the output enable is low and no memory request is issued.
- R2: Input data is sampled on rising serial-clock edges and output data changes on falling edges, most significant bit first. The output enable is low whenever chip select is high, and during the command, address and dummy bytes.
- R3: Command 0x03 reads memory. A 24-bit address follows, of which bits 17:0 are used. Bytes come out at an incrementing address for as long as clocks continue, and address 0x3FFFF is followed by 0x00000.
- R4: Command 0x0B reads like 0x03, but 8 dummy clocks follow the address before the first data bit.
- R5: Command 0x02 takes a 24-bit address and then data bytes. Each complete byte is written at an incrementing address that wraps at the top. A byte is written only while the write-enable latch is set and `wr_permit` is high.
- R6: Command 0x06 sets the write-enable latch and 0x04 clears it. In the status byte, bit 1 is the latch, bit 0 is always 0, and bits 7:2 are a stored field. Reset clears all of them, and array and status writes leave the latch set.
- R7: Command 0x05 returns the status byte repeatedly while clocks continue. Command 0x01 stores data bits 7:2 into the status field, and only while the latch is set and `wr_permit` is high.
- R8: Command 0x9F outputs the bytes 0x04, 0x7F, 0x48 and 0x0A. After the 32nd bit, the output keeps that bit's level and stays enabled until chip select rises.
- R9: If chip select rises before the eighth command bit, nothing is executed.
- R10: An unknown command makes the engine ignore all input until chip select rises. No memory request is made and the output stays disabled.
- R11: SPI mode 0 (clock idle low) and mode 3 (clock idle high) both work for every command.
- R12: A data byte that is cut short by chip select rising is not written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` |
| mem_req | output | 1 | One-cycle memory access request |
| mem_we | output | 1 | Request is a write when high |
| mem_addr | output | 18 | Byte address of the request |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read request |
| wr_permit | input | 1 | External permission for array and status writes |

## Verification
The hardest cases to reach from the pins are those where chip select rises in the middle of a field. One is an abort after seven command bits; the other is a data byte cut off after five bits. The bench drives the pins one bit at a time, so a transfer can stop after any number of bits, and it then proves through a status or memory read that nothing happened. Wrap-around at the top address is reached by writing and reading across 0x3FFFF. The bench RAM model folds the address to ten bits, so the top and bottom locations stay distinct.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    localparam int MEM_ADDR_W = 18;
    localparam int ADDR_FIELD_BITS = 24;
    localparam int DUMMY_BITS = 8;
    localparam int ID_BYTES = 4;
    localparam logic [31:0] DEV_ID_WORD = 32'h047F_480A;

    localparam logic [7:0] OPC_WEN_SET = 8'h06;
    localparam logic [7:0] OPC_WEN_CLR = 8'h04;
    localparam logic [7:0] OPC_STAT_RD = 8'h05;
    localparam logic [7:0] OPC_STAT_WR = 8'h01;
    localparam logic [7:0] OPC_RD      = 8'h03;
    localparam logic [7:0] OPC_RD_FAST = 8'h0B;
    localparam logic [7:0] OPC_WR      = 8'h02;
    localparam logic [7:0] OPC_ID_RD   = 8'h9F;

    typedef enum logic [3:0] {
        CS_OPCODE,
        CS_ADDR,
        CS_DUMMY,
        CS_RDATA,
        CS_WDATA,
        CS_STAT_OUT,
        CS_STAT_IN,
        CS_ID_OUT,
        CS_FINISHED,
        CS_IGNORE
    } ctl_state_t;

    typedef enum logic [1:0] {
        TX_NONE,
        TX_MEM,
        TX_STAT,
        TX_ID
    } tx_src_t;

    typedef struct packed {
        logic active;
        logic rise;
        logic fall;
        logic mosi;
    } pin_evt_t;

    function automatic logic [7:0] id_byte(input logic [1:0] idx);
        return DEV_ID_WORD[31 - 8 * int'(idx) -: 8];
    endfunction

    function automatic logic [7:0] pack_status(input logic [5:0] hi, input logic wen);
        return {hi, wen, 1'b0};
    endfunction

endpackage

// File: rtl/spi_pin_front.sv
module spi_pin_front
    import spi_mem_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     csn_raw,
    input  logic     sck_raw,
    input  logic     mosi_raw,
    output pin_evt_t evt
);

    localparam logic [2:0] IDLE_PINS = 3'b100;

    logic [SYNC_STAGES-1:0][2:0] stage_q;
    logic [2:0] pins_s;
    logic       sck_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q  <= {SYNC_STAGES{IDLE_PINS}};
            sck_prev <= 1'b0;
        end else begin
            stage_q[0] <= {csn_raw, sck_raw, mosi_raw};
            for (int i = 1; i < SYNC_STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
            sck_prev <= pins_s[1];
        end
    end

    assign pins_s     = stage_q[SYNC_STAGES-1];
    assign evt.active = ~pins_s[2];
    assign evt.rise   = ~pins_s[2] &  pins_s[1] & ~sck_prev;
    assign evt.fall   = ~pins_s[2] & ~pins_s[1] &  sck_prev;
    assign evt.mosi   = pins_s[0];

    // R2
    edge_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(evt.rise && evt.fall));

endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W     = MEM_ADDR_W,
    parameter int ADDR_BITS  = ADDR_FIELD_BITS,
    parameter int DUMMY_CLKS = DUMMY_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  pin_evt_t          evt,
    input  logic              wr_permit,
    input  logic              fetch_next,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output tx_src_t           tx_src,
    output logic [7:0]        stat_byte
);

    localparam int CNT_W = $clog2(ADDR_BITS);

    ctl_state_t           state;
    logic [CNT_W-1:0]     cnt;
    logic [7:0]           shreg;
    logic [ADDR_BITS-1:0] addr_sh;
    logic [ADDR_W-1:0]    addr;
    logic                 is_write;
    logic                 is_fast;
    logic                 wen;
    logic [5:0]           stat_hi;

    logic [7:0]           byte_next;
    logic [ADDR_BITS-1:0] addr_next;

    assign byte_next = {shreg[6:0], evt.mosi};
    assign addr_next = {addr_sh[ADDR_BITS-2:0], evt.mosi};
    assign stat_byte = pack_status(stat_hi, wen);

    always_comb begin
        case (state)
            CS_RDATA:    tx_src = TX_MEM;
            CS_STAT_OUT: tx_src = TX_STAT;
            CS_ID_OUT:   tx_src = TX_ID;
            default:     tx_src = TX_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= CS_OPCODE;
            cnt       <= '0;
            shreg     <= '0;
            addr_sh   <= '0;
            addr      <= '0;
            is_write  <= 1'b0;
            is_fast   <= 1'b0;
            wen       <= 1'b0;
            stat_hi   <= '0;
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            if (!evt.active) begin
                state <= CS_OPCODE;
                cnt   <= '0;
            end else begin
                if (evt.rise) begin
                    case (state)
                        CS_OPCODE: begin
                            shreg <= byte_next;
                            cnt   <= cnt + 1'b1;
                            if (cnt == CNT_W'(7)) begin
                                cnt      <= '0;
                                is_write <= 1'b0;
                                is_fast  <= 1'b0;
                                case (byte_next)
                                    OPC_WEN_SET: begin wen <= 1'b1; state <= CS_FINISHED; end
                                    OPC_WEN_CLR: begin wen <= 1'b0; state <= CS_FINISHED; end
                                    OPC_STAT_RD: state <= CS_STAT_OUT;
                                    OPC_STAT_WR: state <= CS_STAT_IN;
                                    OPC_RD:      state <= CS_ADDR;
                                    OPC_RD_FAST: begin is_fast <= 1'b1; state <= CS_ADDR; end
                                    OPC_WR:      begin is_write <= 1'b1; state <= CS_ADDR; end
                                    OPC_ID_RD:   state <= CS_ID_OUT;
                                    default:     state <= CS_IGNORE;
                                endcase
                            end
                        end
                        CS_ADDR: begin
                            addr_sh <= addr_next;
                            cnt     <= cnt + 1'b1;
                            if (cnt == CNT_W'(ADDR_BITS - 1)) begin
                                cnt  <= '0;
                                addr <= addr_next[ADDR_W-1:0];
                                if (is_write) begin
                                    state <= CS_WDATA;
                                end else if (is_fast) begin
                                    state <= CS_DUMMY;
                                end else begin
                                    state    <= CS_RDATA;
                                    mem_req  <= 1'b1;
                                    mem_addr <= addr_next[ADDR_W-1:0];
                                end
                            end
                        end
                        CS_DUMMY: begin
                            cnt <= cnt + 1'b1;
                            if (cnt == CNT_W'(DUMMY_CLKS - 1)) begin
                                cnt      <= '0;
                                state    <= CS_RDATA;
                                mem_req  <= 1'b1;
                                mem_addr <= addr;
                            end
                        end
                        CS_WDATA: begin
                            shreg <= byte_next;
                            cnt   <= cnt + 1'b1;
                            if (cnt == CNT_W'(7)) begin
                                cnt  <= '0;
                                addr <= addr + 1'b1;
                                if (wen && wr_permit) begin
                                    mem_req   <= 1'b1;
                                    mem_we    <= 1'b1;
                                    mem_addr  <= addr;
                                    mem_wdata <= byte_next;
                                end
                            end
                        end
                        CS_STAT_IN: begin
                            shreg <= byte_next;
                            cnt   <= cnt + 1'b1;
                            if (cnt == CNT_W'(7)) begin
                                cnt   <= '0;
                                state <= CS_FINISHED;
                                if (wen && wr_permit) begin
                                    stat_hi <= byte_next[7:2];
                                end
                            end
                        end
                        default: ;
                    endcase
                end
                if (fetch_next && state == CS_RDATA) begin
                    addr     <= addr + 1'b1;
                    mem_req  <= 1'b1;
                    mem_addr <= addr + 1'b1;
                end
            end
        end
    end

    // R5
    wr_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (wen && $past(wr_permit)));

    // R3
    rd_incr_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.active && fetch_next && state == CS_RDATA) |=>
            (mem_req && !mem_we && mem_addr == $past(addr) + 1'b1));

    // R10
    ignore_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == CS_IGNORE) |-> !mem_req);

    // R7
    stat_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(stat_hi) |-> $past(wen && wr_permit));

endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift
    import spi_mem_pkg::*;
#(
    parameter int N_ID_BYTES = ID_BYTES
) (
    input  logic     clk,
    input  logic     rst,
    input  pin_evt_t evt,
    input  tx_src_t  tx_src,
    input  logic [7:0] mem_rdata,
    input  logic [7:0] stat_byte,
    output logic     miso,
    output logic     miso_oe,
    output logic     fetch_next
);

    localparam int IDX_W = $clog2(N_ID_BYTES + 1);

    logic [7:0]       sr;
    logic [2:0]       bcnt;
    logic [IDX_W-1:0] id_idx;
    logic [7:0]       load_byte;
    logic             id_spent;

    always_comb begin
        case (tx_src)
            TX_MEM:  load_byte = mem_rdata;
            TX_STAT: load_byte = stat_byte;
            TX_ID:   load_byte = id_byte(id_idx[1:0]);
            default: load_byte = 8'h00;
        endcase
    end

    assign id_spent = (tx_src == TX_ID) && (id_idx == IDX_W'(N_ID_BYTES)) && (bcnt == 3'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr         <= '1;
            bcnt       <= '0;
            id_idx     <= '0;
            miso       <= 1'b0;
            miso_oe    <= 1'b0;
            fetch_next <= 1'b0;
        end else begin
            fetch_next <= 1'b0;
            if (!evt.active) begin
                miso_oe <= 1'b0;
                bcnt    <= '0;
                id_idx  <= '0;
            end else if (evt.fall && tx_src != TX_NONE) begin
                miso_oe <= 1'b1;
                if (id_spent) begin
                    miso <= miso;
                end else if (bcnt == 3'd0) begin
                    miso <= load_byte[7];
                    sr   <= {load_byte[6:0], 1'b1};
                    bcnt <= 3'd1;
                    if (tx_src == TX_MEM) fetch_next <= 1'b1;
                    if (tx_src == TX_ID)  id_idx <= id_idx + 1'b1;
                end else begin
                    miso <= sr[7];
                    sr   <= {sr[6:0], 1'b1};
                    bcnt <= bcnt + 1'b1;
                end
            end
        end
    end

    // R2
    oe_off_chk: assert property (@(posedge clk) disable iff (rst)
        !evt.active |=> !miso_oe);

    // R2
    oe_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(miso_oe) |-> $past(evt.fall));

    // R8
    id_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.active && evt.fall && id_spent) |=> $stable(miso));

endmodule

// File: rtl/spi_mem_engine.sv
module spi_mem_engine
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W      = MEM_ADDR_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_csn,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              wr_permit
);

    pin_evt_t   evt;
    tx_src_t    tx_src;
    logic [7:0] stat_byte;
    logic       fetch_next;

    spi_pin_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk      (clk),
        .rst      (rst),
        .csn_raw  (spi_csn),
        .sck_raw  (spi_sck),
        .mosi_raw (spi_mosi),
        .evt      (evt)
    );

    spi_cmd_ctrl #(
        .ADDR_W     (ADDR_W),
        .ADDR_BITS  (ADDR_FIELD_BITS),
        .DUMMY_CLKS (DUMMY_BITS)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .wr_permit  (wr_permit),
        .fetch_next (fetch_next),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .tx_src     (tx_src),
        .stat_byte  (stat_byte)
    );

    spi_tx_shift #(.N_ID_BYTES(ID_BYTES)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .tx_src     (tx_src),
        .mem_rdata  (mem_rdata),
        .stat_byte  (stat_byte),
        .miso       (spi_miso),
        .miso_oe    (spi_miso_oe),
        .fetch_next (fetch_next)
    );

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!spi_miso_oe && !mem_req));

endmodule

// File: tb/spi_mem_engine_test.sv
module spi_mem_engine_test;

    localparam int CLK_NS = 20;
    localparam int HALF   = 5 * CLK_NS;

    typedef struct packed {
        logic [7:0]  opc;
        logic [23:0] addr;
        logic [3:0]  nbytes;
        logic        mode3;
    } rd_vec_t;

    localparam int NVEC = 6;
    localparam rd_vec_t RD_TABLE [NVEC] = '{
        '{8'h03, 24'h000010, 4'd3, 1'b0},
        '{8'h0B, 24'h000100, 4'd2, 1'b0},
        '{8'h03, 24'h03FFFE, 4'd4, 1'b0},
        '{8'h03, 24'hFC0020, 4'd2, 1'b1},
        '{8'h0B, 24'h03FFFF, 4'd2, 1'b1},
        '{8'h03, 24'h0002A0, 4'd1, 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_NS/2) clk = ~clk;

    logic        csn = 1'b1, sck = 1'b0, mosi = 1'b0, wr_permit = 1'b1;
    logic        miso, miso_oe, mem_req, mem_we;
    logic [17:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;
    logic [7:0]  ram    [1024];
    logic [7:0]  shadow [1024];
    int          n_chk = 0, n_err = 0;
    logic        oe_seen;

    spi_mem_engine uut (
        .clk(clk), .rst(rst), .spi_csn(csn), .spi_sck(sck), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_oe(miso_oe), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .wr_permit(wr_permit)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) ^ (a >> 2));
    endfunction

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) ram[mem_addr[9:0]] <= mem_wdata;
            else        mem_rdata <= ram[mem_addr[9:0]];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bit_x(input logic b, output logic r);
        sck  = 1'b0;
        mosi = b;
        #(HALF);
        r = miso;
        if (miso_oe) oe_seen = 1'b1;
        sck = 1'b1;
        #(HALF);
    endtask

    task automatic byte_x(input logic [7:0] tx, output logic [7:0] rx);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bit_x(tx[i], r);
            rx[i] = r;
        end
    endtask

    task automatic start(input logic m3);
        sck = m3;
        #(HALF);
        csn = 1'b0;
        #(HALF);
        oe_seen = 1'b0;
    endtask

    task automatic stop(input logic m3);
        if (!m3) begin
            sck = 1'b0;
            #(HALF);
        end
        csn = 1'b1;
        #(4 * HALF);
    endtask

    task automatic mem_read(input logic [7:0] opc, input logic [23:0] a, input int n,
                            input logic m3, input string tag);
        logic [7:0]  r;
        logic [17:0] ak;
        start(m3);
        byte_x(opc, r);
        byte_x(a[23:16], r);
        byte_x(a[15:8], r);
        byte_x(a[7:0], r);
        if (opc == 8'h0B) byte_x(8'h00, r);
        chk({tag, " R2 header hi-z"}, 32'(oe_seen), 32'd0);
        for (int k = 0; k < n; k++) begin
            byte_x(8'h00, r);
            ak = a[17:0] + 18'(k);
            chk(tag, 32'(r), 32'(shadow[ak[9:0]]));
        end
        stop(m3);
        chk({tag, " R2 cs high hi-z"}, 32'(miso_oe), 32'd0);
    endtask

    task automatic mem_write(input logic [23:0] a, input logic [7:0] d0, input logic [7:0] d1,
                             input int n, input int extra_bits, input logic m3);
        logic [7:0] r;
        logic       rb;
        start(m3);
        byte_x(8'h02, r);
        byte_x(a[23:16], r);
        byte_x(a[15:8], r);
        byte_x(a[7:0], r);
        byte_x(d0, r);
        if (n > 1) byte_x(d1, r);
        for (int i = 0; i < extra_bits; i++) bit_x(1'b1, rb);
        stop(m3);
    endtask

    task automatic one_cmd(input logic [7:0] opc);
        logic [7:0] r;
        start(1'b0);
        byte_x(opc, r);
        stop(1'b0);
    endtask

    task automatic stat_write(input logic [7:0] d);
        logic [7:0] r;
        start(1'b0);
        byte_x(8'h01, r);
        byte_x(d, r);
        stop(1'b0);
    endtask

    task automatic stat_check(input logic [7:0] exp, input int n, input string tag);
        logic [7:0] r;
        start(1'b0);
        byte_x(8'h05, r);
        for (int k = 0; k < n; k++) begin
            byte_x(8'h00, r);
            chk(tag, 32'(r), 32'(exp));
        end
        stop(1'b0);
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic       rb;
        for (int i = 0; i < 1024; i++) begin
            ram[i]    = pat(i);
            shadow[i] = pat(i);
        end
        repeat (5) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 oe after reset", 32'(miso_oe), 32'd0);
        chk("R1 req after reset", 32'(mem_req), 32'd0);

        // vector table: R3 R4 R11 reads, including wrap and ignored upper address bits
        for (int v = 0; v < NVEC; v++) begin
            mem_read(RD_TABLE[v].opc, RD_TABLE[v].addr, int'(RD_TABLE[v].nbytes),
                     RD_TABLE[v].mode3, (RD_TABLE[v].opc == 8'h0B) ? "R4 R11 fast read" : "R3 R11 read");
        end

        stat_check(8'h00, 1, "R6 status after reset");

        mem_write(24'h000040, 8'hC3, 8'h00, 1, 0, 1'b0);
        mem_read(8'h03, 24'h000040, 1, 1'b0, "R5 write without latch ignored");

        one_cmd(8'h06);
        stat_check(8'h02, 3, "R7 R6 repeated status after set");

        mem_write(24'h000041, 8'hA5, 8'h5A, 2, 0, 1'b0);
        shadow[10'h041] = 8'hA5;
        shadow[10'h042] = 8'h5A;
        mem_read(8'h03, 24'h000041, 2, 1'b0, "R5 burst write");
        stat_check(8'h02, 1, "R6 latch kept after write");

        wr_permit = 1'b0;
        mem_write(24'h000043, 8'h77, 8'h00, 1, 0, 1'b0);
        wr_permit = 1'b1;
        mem_read(8'h03, 24'h000043, 1, 1'b0, "R5 permit low blocks write");

        mem_write(24'h000044, 8'h11, 8'h00, 1, 5, 1'b0);
        shadow[10'h044] = 8'h11;
        mem_read(8'h03, 24'h000044, 2, 1'b0, "R12 partial byte dropped");

        stat_write(8'hFF);
        stat_check(8'hFE, 1, "R7 status write");
        wr_permit = 1'b0;
        stat_write(8'h00);
        wr_permit = 1'b1;
        stat_check(8'hFE, 1, "R7 status write blocked");
        stat_write(8'h00);
        stat_check(8'h02, 1, "R7 R6 status cleared latch kept");

        mem_write(24'h03FFFF, 8'h99, 8'h66, 2, 0, 1'b1);
        shadow[10'h3FF] = 8'h99;
        shadow[10'h000] = 8'h66;
        mem_read(8'h03, 24'h03FFFF, 2, 1'b0, "R3 R5 R11 write wrap");

        one_cmd(8'h04);
        stat_check(8'h00, 1, "R6 latch cleared");
        mem_write(24'h000045, 8'hEE, 8'h00, 1, 0, 1'b0);
        mem_read(8'h03, 24'h000045, 1, 1'b0, "R5 write after clear ignored");

        one_cmd(8'h06);
        start(1'b0);
        for (int i = 7; i >= 1; i--) bit_x(OPC_BITS_WEN_CLR(i), rb);
        stop(1'b0);
        stat_check(8'h02, 1, "R9 aborted op-code not run");

        one_cmd(8'h04);
        start(1'b0);
        byte_x(8'h5A, r);
        byte_x(8'h06, r);
        byte_x(8'h05, r);
        byte_x(8'h00, r);
        chk("R10 unknown op-code output stays off", 32'(oe_seen), 32'd0);
        stop(1'b0);
        stat_check(8'h00, 1, "R10 trailing bytes ignored");

        start(1'b0);
        byte_x(8'h9F, r);
        byte_x(8'h00, r); chk("R8 id byte 0", 32'(r), 32'h04);
        byte_x(8'h00, r); chk("R8 id byte 1", 32'(r), 32'h7F);
        byte_x(8'h00, r); chk("R8 id byte 2", 32'(r), 32'h48);
        byte_x(8'h00, r); chk("R8 id byte 3", 32'(r), 32'h0A);
        byte_x(8'h00, r); chk("R8 hold last bit", 32'(r), 32'h00);
        chk("R8 output still on", 32'(miso_oe), 32'd1);
        stop(1'b0);

        start(1'b1);
        byte_x(8'h9F, r);
        byte_x(8'h00, r); chk("R11 mode3 id byte 0", 32'(r), 32'h04);
        byte_x(8'h00, r); chk("R11 mode3 id byte 1", 32'(r), 32'h7F);
        stop(1'b1);
        chk("R2 output off after cs high", 32'(miso_oe), 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    // bits 7..1 of the latch-clear op-code 0x04, sent MSB first
    function automatic logic OPC_BITS_WEN_CLR(input int i);
        logic [7:0] v;
        v = 8'h04;
        return v[i];
    endfunction

endmodule